// File: doc/BRIEF.md
# Chained 64-bit Lifetime Counter with Coherent Read Snapshot

The block links two down-counting channels into one 64-bit lifetime count. The low channel steps down on every enabled tick. The high channel steps down once each time the low channel expires, so together they behave as a single wide counter. When linking is turned off, the high channel instead steps on every tick. Each channel reloads its own configured start value on the tick after it has reached zero.

Software reads the count over a small read-only register bus that exposes two words. Reading the high word returns the live high channel. On that same clock edge it copies the live low channel into a shadow register. A following read of the low word returns the shadow and not the live count. A high-then-low read pair therefore yields a coherent 64-bit value even when a borrow passes between the channels during the two reads.

A global run enable gates all counting. A freeze setting decides whether counting also stops while the debug-mode input is high.

Top module: `lifetime_timer`

## Requirements
- R1: While reset is active, both channel counts, the shadow register and `bus_rdata` are all zero.
- R2: On an active tick, the low channel decreases by one when it is non-zero. A tick is active when `run_en` is high and the halt condition of R9 does not hold.
- R3: On an active tick with the low channel at zero, the low channel takes `load_lo`. The high channel behaves the same way with `load_hi`.
- R4: With `chain_en` high, the high channel changes only on an active tick where the low channel is zero, and then by one step (decrement, or reload per R3).
- R5: With `chain_en` low, the high channel steps on every active tick.
- R6: A read at address 0x00 (high word) loads `bus_rdata` with the high channel's count as it was before that edge. On the same edge it copies the low channel's pre-edge count into the shadow.
- R7: A read at address 0x04 (low word) loads `bus_rdata` with the shadow. The shadow changes only on a high-word read, so it stays the same across any number of low-word reads.
- R8: Bus writes have no effect on the counts, the shadow or `bus_rdata`.
- R9: When `dbg_mode` and `freeze_dbg` are both high, neither channel changes. When `freeze_dbg` is low, counting continues while `dbg_mode` is high.
- R10: When `run_en` is low, neither channel changes.
- R11: `bus_rdata` changes only on a read edge. A read at any address other than 0x00 or 0x04 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Global counting enable |
| dbg_mode | input | 1 | Debug-mode indication |
| freeze_dbg | input | 1 | 1: halt counting while in debug mode |
| chain_en | input | 1 | 1: high channel steps on low-channel expiry |
| load_lo | input | W | Reload value of the low channel |
| load_hi | input | W | Reload value of the high channel |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe (ignored) |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | W | Write data (ignored) |
| bus_rdata | output | W | Read data, registered, valid the cycle after the strobe |

## Verification
The bench builds the block with an 8-bit channel width and small reload values. This lets low-channel expiries, borrows into the high channel and high-channel wraparound all happen within a few hundred cycles. With short reload periods, a borrow often lands between a high read and the low read that follows it, which exercises the snapshot coherence directly.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFS_HI = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_LO = 8'h04;

  typedef enum logic [1:0] {SEL_NONE, SEL_HI, SEL_LO} rd_sel_e;

  function automatic rd_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    if (a == OFS_HI) return SEL_HI;
    if (a == OFS_LO) return SEL_LO;
    return SEL_NONE;
  endfunction
endpackage

// File: rtl/lt_channel.sv
module lt_channel #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         expire
);
  localparam logic [W-1:0] ONE = W'(1);

  logic at_zero;
  assign at_zero = (count == '0);
  assign expire  = tick && at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (tick)   count <= at_zero ? load_val : count - ONE;
  end

  a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count != '0) |=> count == $past(count) - ONE);
  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == '0) |=> count == $past(load_val));
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));
endmodule

// File: rtl/lt_readport.sv
module lt_readport
  import lt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      hi_live,
  input  logic [W-1:0]      lo_live,
  output logic [W-1:0]      rdata
);
  rd_sel_e     sel;
  logic [W-1:0] shadow;

  assign sel = decode_addr(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      rdata  <= '0;
    end else if (rd) begin
      unique case (sel)
        SEL_HI: begin
          rdata  <= hi_live;
          shadow <= lo_live;
        end
        SEL_LO:   rdata <= shadow;
        default:  rdata <= '0;
      endcase
    end
  end

  a_r7_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && sel == SEL_HI) |=> $stable(shadow));
  a_r6_capture_low: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel == SEL_HI) |=> shadow == $past(lo_live));
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel == SEL_NONE) |=> rdata == '0);
endmodule

// File: rtl/lifetime_timer.sv
module lifetime_timer
  import lt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              dbg_mode,
  input  logic              freeze_dbg,
  input  logic              chain_en,
  input  logic [W-1:0]      load_lo,
  input  logic [W-1:0]      load_hi,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata
);
  logic         tick;
  logic         tick_hi;
  logic         exp_lo;
  logic         exp_hi;
  logic [W-1:0] cnt_lo;
  logic [W-1:0] cnt_hi;

  assign tick    = run_en && !(dbg_mode && freeze_dbg);
  assign tick_hi = chain_en ? exp_lo : tick;

  lt_channel #(.W(W)) u_lo (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load_val(load_lo),
    .count(cnt_lo), .expire(exp_lo)
  );

  lt_channel #(.W(W)) u_hi (
    .clk(clk), .rst_n(rst_n), .tick(tick_hi), .load_val(load_hi),
    .count(cnt_hi), .expire(exp_hi)
  );

  lt_readport #(.W(W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd(bus_rd), .addr(bus_addr),
    .hi_live(cnt_hi), .lo_live(cnt_lo), .rdata(bus_rdata)
  );

  a_r9_freeze_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_mode && freeze_dbg) |=> ($stable(cnt_lo) && $stable(cnt_hi)));
  a_r4_chain_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_en && cnt_lo != '0) |=> $stable(cnt_hi));
  a_r5_free_run: assert property (@(posedge clk) disable iff (!rst_n)
    (!chain_en && run_en && !dbg_mode) |=> !$stable(cnt_hi) || $past(cnt_hi) == '0);
  a_r8_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && bus_wdata != '0) |=> $stable(bus_rdata));
  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_n |-> (cnt_lo == '0 && cnt_hi == '0 && bus_rdata == '0));

  logic unused_exp;
  assign unused_exp = exp_hi;
endmodule

// File: tb/sim_lifetime_timer.sv
module sim_lifetime_timer;
  localparam int W = 8;
  localparam int M = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 0, dbg_mode = 0, freeze_dbg = 0, chain_en = 0;
  logic [W-1:0] load_lo = 0, load_hi = 0, bus_wdata = 0;
  logic bus_rd = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [W-1:0] bus_rdata;

  always #4 clk = ~clk;

  lifetime_timer #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .dbg_mode(dbg_mode),
    .freeze_dbg(freeze_dbg), .chain_en(chain_en), .load_lo(load_lo),
    .load_hi(load_hi), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  int m_lo = 0, m_hi = 0, m_sh = 0, m_rd = 0;
  int errors = 0, checks = 0;
  string req = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; m_sh = 0; m_rd = 0;
    end else begin
      bit t, e0, t1;
      t  = run_en && !(dbg_mode && freeze_dbg);
      e0 = t && (m_lo == 0);
      t1 = chain_en ? e0 : t;
      if (bus_rd) begin
        if (bus_addr == 8'h00) begin m_rd = m_hi; m_sh = m_lo; end
        else if (bus_addr == 8'h04) m_rd = m_sh;
        else m_rd = 0;
      end
      if (t)  m_lo = (m_lo == 0) ? int'(load_lo) : (m_lo - 1) % M;
      if (t1) m_hi = (m_hi == 0) ? int'(load_hi) : (m_hi - 1) % M;
    end
  end

  task automatic check_now();
    checks++;
    if (int'(bus_rdata) != m_rd) begin
      errors++;
      $display("FAIL %s: bus_rdata=%0d expected=%0d at %0t", req, bus_rdata, m_rd, $time);
    end
  endtask

  task automatic cyc(input bit rd, input logic [7:0] a);
    @(negedge clk);
    check_now();
    bus_rd = rd; bus_addr = a;
  endtask

  task automatic pairs(input int n);
    for (int i = 0; i < n; i++) begin
      cyc(1, 8'h00);
      cyc(1, 8'h04);
    end
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    req = "R1";
    bus_rd = 1; bus_addr = 8'h00;
    run_en = 1; load_lo = 8'd3; load_hi = 8'd5;
    repeat (3) cyc(1, 8'h00);
    @(negedge clk); check_now();
    rst_n = 1;
    bus_rd = 0;

    // R2 R3 R4 R6 R7: chained count with high/low read pairs
    req = "R2 R3 R4 R6 R7"; chain_en = 1;
    pairs(80);

    // R7: repeated low reads return the held shadow
    req = "R7";
    cyc(1, 8'h00);
    for (int i = 0; i < 10; i++) cyc(1, 8'h04);

    // R11: idle cycles keep bus_rdata, unmapped reads give zero
    req = "R11";
    for (int i = 0; i < 5; i++) cyc(0, 8'h00);
    cyc(1, 8'h08); cyc(1, 8'hFF); cyc(0, 8'h00);

    // R5: unchained, high channel runs on every tick
    req = "R5"; chain_en = 0; load_hi = 8'd7;
    pairs(30);

    // R9: debug without freeze keeps counting, then freeze halts
    req = "R9"; dbg_mode = 1; freeze_dbg = 0;
    pairs(10);
    freeze_dbg = 1;
    pairs(10);
    dbg_mode = 0; freeze_dbg = 1;
    pairs(5);

    // R10: run disabled holds both channels
    req = "R10"; run_en = 0;
    pairs(10);
    run_en = 1;

    // R8: writes change nothing observable
    req = "R8"; chain_en = 1; load_lo = 8'd2;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); check_now();
      bus_rd = 0; bus_wr = 1; bus_addr = (i % 2 == 0) ? 8'h00 : 8'h04;
      bus_wdata = W'(8'hA5 + i);
      @(negedge clk); check_now();
      bus_wr = 0; bus_rd = 1; bus_addr = 8'h00;
      @(negedge clk); check_now();
      bus_addr = 8'h04;
    end
    cyc(0, 8'h00);
    cyc(0, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule